// File: doc/BRIEF.md
# Receive Byte Buffer with Frame Status Flags

This block is the receive-side byte store of a packet radio. A receiver front end writes the bytes of each incoming frame into it. The length byte comes first, then the frame body. A host pops the bytes in arrival order. Up to 128 bytes are held at once, and that space is shared by as many whole or partial frames as fit.

Four status outputs summarise the store. The frame flag follows reception of the current frame. The data flag shows that bytes are waiting. The threshold flag tells the host that enough bytes, or a whole packet, can be read. The overflow flag marks a lost byte.

When address filtering is on, the front end reports a pass or fail result for each frame. Until a frame passes, its bytes cannot be read and the threshold flag stays quiet. A failed frame is erased at once, and frames stored before it are left as they were.

An overflow is shown to the host as data flag low with threshold flag high. The store then refuses new frames until a flush command empties it.

Top module: `rxbuf_flags`

## Requirements
- R1: Bytes are read back in the order they were written, with `rd_data_o` showing the oldest unread byte. The store holds up to 128 bytes.
- R2: `present_o` is high whenever at least one byte is stored, from the write of a frame's length byte until the last byte is popped. It is low when the store is empty.
- R3: `frame_o` rises the cycle after `sof_i` and falls the cycle after the frame's last byte (`wr_valid_i` with `eof_i`) has been written.
- R4: A filtered frame that fails (`addr_done_i` with `addr_ok_i` low) is removed within one cycle. `frame_o` falls, the write position returns to that frame's length byte, and earlier frames stay readable and unchanged.
- R5: Without a pending filter result, `thresh_o` is high whenever the stored byte count is strictly greater than `thr_i`.
- R6: While `addr_en_i` is set and the current frame has not yet passed, the count comparison of `thresh_o` is suppressed. It takes effect the cycle after the pass.
- R7: Writing a frame's last byte raises `thresh_o` even below the threshold. That packet-ready condition clears after one byte is popped.
- R8: A write into a full store sets a sticky overflow. The byte is discarded, `ovf_o` is high, `present_o` is low and `thresh_o` is high. Stored bytes remain readable.
- R9: During overflow, `sof_i` and frame bytes are ignored until `flush_i`.
- R10: `flush_i` empties the store, clears overflow and drives all four flags low on the next cycle.
- R11: A last byte that arrives while its frame still waits for a filter result is treated as a failure, and the frame is removed.
- R12: A pop is ignored when no readable byte exists. Bytes of a frame still waiting for a filter result are not readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start-of-frame pulse, delimiter received |
| wr_valid_i | input | 1 | Frame byte valid |
| wr_data_i | input | 8 | Frame byte |
| eof_i | input | 1 | Qualifies `wr_valid_i`: last byte of frame |
| addr_en_i | input | 1 | Address filtering enabled |
| addr_done_i | input | 1 | Filter result valid pulse |
| addr_ok_i | input | 1 | Filter result: 1 pass, 0 fail |
| thr_i | input | 7 | Threshold for unread byte count |
| rd_i | input | 1 | Pop request |
| rd_data_o | output | 8 | Oldest readable byte |
| flush_i | input | 1 | Flush command |
| frame_o | output | 1 | Frame reception active |
| present_o | output | 1 | Data present |
| thresh_o | output | 1 | Threshold or packet ready |
| ovf_o | output | 1 | Overflow |

## Verification
Every input takes effect at the next rising edge. Each flag and `rd_data_o` is decoded from registered state with no further stage, so every result is due exactly one cycle after its stimulus. The bench changes inputs just after a rising edge and samples the outputs just after the following edge. No output is read in the cycle where its cause is still being applied. Ignored pops and rejected frames are judged through the bytes that appear on `rd_data_o` afterwards.

// File: rtl/rxbuf_flags.sv
module rxbuf_flags #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CNTW = PTRW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sof_i,
  input  logic            wr_valid_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            eof_i,
  input  logic            addr_en_i,
  input  logic            addr_done_i,
  input  logic            addr_ok_i,
  input  logic [PTRW-1:0] thr_i,
  input  logic            rd_i,
  output logic [DW-1:0]   rd_data_o,
  input  logic            flush_i,
  output logic            frame_o,
  output logic            present_o,
  output logic            thresh_o,
  output logic            ovf_o
);

  logic [DW-1:0]   mem [DEPTH];
  logic [PTRW-1:0] wp, rp, fstart;
  logic [CNTW-1:0] cnt, fcnt;
  logic            active, pending, pkt_rdy, ovf;

  wire             wr_try   = wr_valid_i & active & ~ovf;
  wire             full     = (cnt == CNTW'(DEPTH));
  wire             reject   = pending & ((addr_done_i & ~addr_ok_i) | (wr_try & eof_i));
  wire             wr_acc   = wr_try & ~full & ~reject;
  wire             ovf_hit  = wr_try & full & ~reject;
  wire [CNTW-1:0]  readable = pending ? cnt - fcnt : cnt;
  wire             rd_acc   = rd_i & (readable != '0);
  wire             sof_acc  = sof_i & ~ovf;

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wp] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fstart <= '0; cnt <= '0; fcnt <= '0;
      active <= 1'b0; pending <= 1'b0; pkt_rdy <= 1'b0; ovf <= 1'b0;
    end else if (flush_i) begin
      wp <= '0; rp <= '0; fstart <= '0; cnt <= '0; fcnt <= '0;
      active <= 1'b0; pending <= 1'b0; pkt_rdy <= 1'b0; ovf <= 1'b0;
    end else begin
      if (rd_acc) rp <= rp + 1'b1;
      if (reject)      wp <= fstart;
      else if (wr_acc) wp <= wp + 1'b1;
      cnt <= (reject ? cnt - fcnt : cnt + CNTW'(wr_acc)) - CNTW'(rd_acc);
      if (sof_acc) begin
        fstart <= wp;
        fcnt   <= '0;
      end else if (wr_acc) begin
        fcnt <= fcnt + 1'b1;
      end
      if (sof_acc) active <= 1'b1;
      else if (reject | (wr_valid_i & active & eof_i)) active <= 1'b0;
      if (sof_acc) pending <= addr_en_i;
      else if (reject | ovf_hit | (addr_done_i & addr_ok_i) | (wr_acc & eof_i)) pending <= 1'b0;
      if (wr_acc & eof_i) pkt_rdy <= 1'b1;
      else if (rd_acc)    pkt_rdy <= 1'b0;
      if (ovf_hit) ovf <= 1'b1;
    end
  end

  assign rd_data_o = mem[rp];
  assign frame_o   = active;
  assign present_o = (cnt != '0) & ~ovf;
  assign thresh_o  = ovf | pkt_rdy | (~pending & (cnt > {1'b0, thr_i}));
  assign ovf_o     = ovf;

endmodule

module rxbuf_flags_chk (
  input logic clk,
  input logic rst_n,
  input logic sof_i,
  input logic flush_i,
  input logic frame_o,
  input logic present_o,
  input logic thresh_o,
  input logic ovf_o
);
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!frame_o && !present_o && !thresh_o && !ovf_o));
  a_r8_ovf_signature: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (!present_o && thresh_o));
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !flush_i) |=> ovf_o);
  a_r9_sof_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !flush_i && !frame_o) |=> !frame_o);
  a_r3_frame_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_i && !ovf_o && !flush_i) |=> frame_o);
endmodule

bind rxbuf_flags rxbuf_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .flush_i(flush_i),
  .frame_o(frame_o), .present_o(present_o), .thresh_o(thresh_o), .ovf_o(ovf_o)
);

// File: tb/rxbuf_flags_tb.sv
module rxbuf_flags_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sof_i = 0, wr_valid_i = 0, eof_i = 0, addr_en_i = 0, addr_done_i = 0, addr_ok_i = 0;
  logic rd_i = 0, flush_i = 0;
  logic [7:0] wr_data_i = 0;
  logic [6:0] thr_i = 7'd2;
  logic [7:0] rd_data_o;
  logic frame_o, present_o, thresh_o, ovf_o;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  rxbuf_flags u_dut (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
    .eof_i(eof_i), .addr_en_i(addr_en_i), .addr_done_i(addr_done_i), .addr_ok_i(addr_ok_i),
    .thr_i(thr_i), .rd_i(rd_i), .rd_data_o(rd_data_o), .flush_i(flush_i),
    .frame_o(frame_o), .present_o(present_o), .thresh_o(thresh_o), .ovf_o(ovf_o)
  );

  // {sof, wr_valid, eof, rd, data[7:0], frame, present, thresh}
  localparam logic [14:0] VEC [12] = '{
    {4'b1000, 8'h00, 3'b100},
    {4'b0100, 8'h03, 3'b110},
    {4'b0100, 8'hA1, 3'b110},
    {4'b0100, 8'hA2, 3'b111},
    {4'b0110, 8'hA3, 3'b011},
    {4'b0001, 8'h00, 3'b011},
    {4'b0001, 8'h00, 3'b010},
    {4'b0001, 8'h00, 3'b010},
    {4'b0001, 8'h00, 3'b000},
    {4'b1000, 8'h00, 3'b100},
    {4'b0110, 8'h00, 3'b011},
    {4'b0001, 8'h00, 3'b000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
    sof_i = 0; wr_valid_i = 0; eof_i = 0; rd_i = 0; addr_done_i = 0; addr_ok_i = 0; flush_i = 0;
  endtask

  task automatic wr(input logic [7:0] d, input logic last);
    wr_valid_i = 1; wr_data_i = d; eof_i = last; tick();
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    #(CLK_P * 3); tick(); rst_n = 1; tick();
    chk("R10 reset frame", frame_o, 0);
    chk("R2 reset present", present_o, 0);
    chk("R5 reset thresh", thresh_o, 0);
    chk("R8 reset ovf", ovf_o, 0);

    // R3 R5 R7 R2 vector walk, thr=2, no filtering
    for (int i = 0; i < 12; i++) begin
      sof_i = VEC[i][14]; wr_valid_i = VEC[i][13]; eof_i = VEC[i][12]; rd_i = VEC[i][11];
      wr_data_i = VEC[i][10:3];
      tick();
      chk($sformatf("R3/R5/R7 vec%0d", i), {frame_o, present_o, thresh_o}, VEC[i][2:0]);
    end

    // R1 ordering
    sof_i = 1; tick();
    wr(8'h11, 0); wr(8'h22, 0); wr(8'h33, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R1 order", rd_data_o, 8'h11 * (i + 1));
      rd_i = 1; tick();
    end
    chk("R2 empty after pops", present_o, 0);

    // R6 R12 R4 filtering
    addr_en_i = 1; thr_i = 0;
    sof_i = 1; tick();
    wr(8'h02, 0); wr(8'hB1, 0);
    chk("R6 thresh held", thresh_o, 0);
    chk("R2 present pending", present_o, 1);
    rd_i = 1; tick();
    addr_done_i = 1; addr_ok_i = 1; tick();
    chk("R6 thresh after pass", thresh_o, 1);
    chk("R12 pop ignored", rd_data_o, 8'h02);
    wr(8'hB2, 1);
    chk("R3 frame falls", frame_o, 0);
    sof_i = 1; tick();
    wr(8'h01, 0); wr(8'hC1, 0);
    addr_done_i = 1; addr_ok_i = 0; tick();
    chk("R4 frame falls on fail", frame_o, 0);
    chk("R4 earlier byte0", rd_data_o, 8'h02); rd_i = 1; tick();
    chk("R4 earlier byte1", rd_data_o, 8'hB1); rd_i = 1; tick();
    chk("R4 earlier byte2", rd_data_o, 8'hB2); rd_i = 1; tick();
    chk("R4 rejected gone", present_o, 0);

    // R11 last byte while pending
    sof_i = 1; tick();
    wr(8'h05, 0); wr(8'h06, 1);
    chk("R11 frame ends", frame_o, 0);
    chk("R11 removed", present_o, 0);

    // R8 R9 R10 overflow
    addr_en_i = 0; thr_i = 7'd2;
    sof_i = 1; tick();
    for (int i = 0; i < 128; i++) wr(i[7:0], 0);
    chk("R1 full present", present_o, 1);
    chk("R8 no ovf yet", ovf_o, 0);
    wr(8'hEE, 0);
    chk("R8 ovf set", ovf_o, 1);
    chk("R8 present low", present_o, 0);
    chk("R8 thresh high", thresh_o, 1);
    chk("R8 data intact", rd_data_o, 8'h00);
    rd_i = 1; tick();
    chk("R8 readable", rd_data_o, 8'h01);
    wr(8'hEF, 1);
    chk("R9 frame ends", frame_o, 0);
    sof_i = 1; tick();
    chk("R9 sof ignored", frame_o, 0);
    chk("R9 ovf sticky", ovf_o, 1);
    flush_i = 1; tick();
    chk("R10 flush flags", {frame_o, present_o, thresh_o, ovf_o}, 4'b0000);
    sof_i = 1; tick();
    chk("R10 reception resumes", frame_o, 1);
    wr(8'h42, 1);
    chk("R10 new byte", rd_data_o, 8'h42);

    finish_run();
  end
endmodule